// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block sits behind the CPU register port of an eight-input interrupt controller. Each write carries one address bit and one data byte. The block sorts each write into one of two kinds. The first kind is the bytes of an initialization sequence, which is two to four bytes long. The second kind is the operation commands that the CPU may send at any time once that sequence has ended. The block holds the fields that initialization programs, and it applies the defaults that a restart forces. It also keeps the mask, the special-mask flag, the status-read selection and the lowest-priority level.

The block also contains one request latch per input. A latch captures a low-to-high transition, or simply follows the input in level mode, and holds it until the request is acknowledged or the input falls. Whenever initialization starts, the block clears the edge history and pulses a signal for one cycle, so that a request input already sitting high must first go low and rise again.

Inputs are sampled on the rising clock edge, and every output is registered. A write therefore shows its effect on the outputs one cycle later.

Top module: `pic_init_seq`

## Requirements
- R1: A write with `wr_addr`=0 and `wr_data[4]`=1 restarts initialization from any state. On the next cycle `seq_ready` is 0, and `cfg_level`, `cfg_single` and `cfg_need4` equal data bits 3, 1 and 0 of that write.
- R2: While initialization is in progress, each write with `wr_addr`=1 advances the sequence. The second byte goes to `vec_base`. The third byte goes to `casc_word` and is expected only when `cfg_single`=0. The fourth byte goes to `mode_word` and is expected only when `cfg_need4`=1. `seq_ready` returns to 1 on the cycle after the last expected byte.
- R3: Starting initialization sets `imr` to 0, `smm_on` to 0, `read_isr` to 0 (status reads return the request register) and `lowest_lvl` to 7.
- R4: `edge_rst` is high for exactly the cycle that follows each initialization start, and is low at all other times.
- R5: In edge mode, an input that is high when initialization starts does not set its `irr` bit until it has gone low and then high again.
- R6: In edge mode, a low-to-high transition sets the `irr` bit. The bit stays set until the matching `ack_clr` bit is high or the input is low. A bit cleared by `ack_clr` does not set again while the input stays high.
- R7: In level mode (`cfg_level`=1), an `irr` bit follows its input one cycle later, and `ack_clr` does not clear it while the input stays high.
- R8: When `seq_ready`=1, a write with `wr_addr`=1 loads `imr` with the data byte.
- R9: When `seq_ready`=1, a write with `wr_addr`=0, bit 4 = 0 and bit 3 = 1 is a mode command. If bit 6 = 1, `smm_on` takes bit 5. If bit 1 = 1, `read_isr` takes bit 0. When the enable bit is 0, the flag does not change.
- R10: When `seq_ready`=1, a write with `wr_addr`=0, bit 4 = 0, bit 3 = 0 and bits 7:5 = 110 sets `lowest_lvl` to bits 2:0. Any other value of bits 7:5 leaves `lowest_lvl` unchanged.
- R11: While initialization is in progress, writes with `wr_addr`=0 and bit 4 = 0 are ignored. While initialization is in progress, writes with `wr_addr`=1 never change `imr`.
- R12: After reset, `seq_ready`=1, `lowest_lvl`=7, `edge_rst`=0, and `irr`, `imr`, `smm_on`, `read_isr` and all configuration fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| wr_addr | input | 1 | Register address bit |
| wr_data | input | 8 | Write data byte |
| irq_in | input | 8 | Interrupt request inputs |
| ack_clr | input | 8 | Per-level acknowledge, clears a latched request |
| seq_ready | output | 1 | High when no initialization is in progress |
| cfg_level | output | 1 | Level-triggered mode selected |
| cfg_single | output | 1 | Single-controller mode, so the third byte is skipped |
| cfg_need4 | output | 1 | Fourth byte expected |
| vec_base | output | 8 | Second initialization byte |
| casc_word | output | 8 | Third initialization byte |
| mode_word | output | 8 | Fourth initialization byte |
| imr | output | 8 | Interrupt mask register |
| smm_on | output | 1 | Special mask mode flag |
| read_isr | output | 1 | Status read selects in-service (1) or request (0) register |
| lowest_lvl | output | 3 | Level currently holding lowest priority |
| edge_rst | output | 1 | One-cycle pulse resetting the edge detectors |
| irr | output | 8 | Latched interrupt requests |

## Verification
The bench restarts initialization while an input is already high and in the same cycle that a second input rises. A design that keeps the old edge history would latch those requests at once instead of waiting for a fresh rise. The bench also drives every sequence length (two, three and four bytes), and it restarts halfway through a sequence. A sequencer that decodes the skip flags wrongly then either stays busy, so that mask writes are taken as sequence bytes, or returns to ready too early. Writes that arrive during initialization on the command address check that mode commands are not acted on early. Acknowledge pulses in edge mode and in level mode check that a cleared request comes back only in level mode.

// File: rtl/pic_init_pkg.sv
package pic_init_pkg;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_W2    = 2'd1,
    ST_W3    = 2'd2,
    ST_W4    = 2'd3
  } seq_st_e;

  typedef struct packed {
    logic level;
    logic single;
    logic need4;
  } icw_flags_t;

endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode (
  input  logic wr_en,
  input  logic wr_addr,
  input  logic cmd_d4,
  input  logic cmd_d3,
  input  logic ready,
  output logic init_hit,
  output logic seq_wr,
  output logic mask_wr,
  output logic ocw2_wr,
  output logic ocw3_wr
);
  always_comb begin
    init_hit = wr_en & ~wr_addr & cmd_d4;
    seq_wr   = wr_en &  wr_addr & ~ready;
    mask_wr  = wr_en &  wr_addr &  ready;
    ocw2_wr  = wr_en & ~wr_addr & ~cmd_d4 & ~cmd_d3 & ready;
    ocw3_wr  = wr_en & ~wr_addr & ~cmd_d4 &  cmd_d3 & ready;
  end
endmodule

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
  import pic_init_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_hit,
  input  logic          seq_wr,
  input  logic [DW-1:0] wr_data,
  output logic          seq_ready,
  output icw_flags_t    flags,
  output logic [DW-1:0] vec_base,
  output logic [DW-1:0] casc_word,
  output logic [DW-1:0] mode_word
);
  seq_st_e    st_q, st_d;
  icw_flags_t flags_d;
  logic       vec_en, casc_en, mode_en;

  always_comb begin
    st_d    = st_q;
    flags_d = flags;
    vec_en  = 1'b0;
    casc_en = 1'b0;
    mode_en = 1'b0;
    if (init_hit) begin
      st_d    = ST_W2;
      flags_d = '{level: wr_data[3], single: wr_data[1], need4: wr_data[0]};
    end else if (seq_wr) begin
      unique case (st_q)
        ST_W2: begin
          vec_en = 1'b1;
          if (!flags.single)    st_d = ST_W3;
          else if (flags.need4) st_d = ST_W4;
          else                  st_d = ST_READY;
        end
        ST_W3: begin
          casc_en = 1'b1;
          st_d    = flags.need4 ? ST_W4 : ST_READY;
        end
        ST_W4: begin
          mode_en = 1'b1;
          st_d    = ST_READY;
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_READY;
      flags     <= '0;
      vec_base  <= '0;
      casc_word <= '0;
      mode_word <= '0;
    end else begin
      st_q  <= st_d;
      flags <= flags_d;
      if (vec_en)  vec_base  <= wr_data;
      if (casc_en) casc_word <= wr_data;
      if (mode_en) mode_word <= wr_data;
    end
  end

  assign seq_ready = (st_q == ST_READY);
endmodule

// File: rtl/pic_op_regs.sv
module pic_op_regs #(
  parameter int N_IRQ = 8,
  parameter int DW    = 8,
  localparam int LW   = $clog2(N_IRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_hit,
  input  logic             mask_wr,
  input  logic             ocw2_wr,
  input  logic             ocw3_wr,
  input  logic [DW-1:0]    wr_data,
  output logic [N_IRQ-1:0] imr,
  output logic             smm_on,
  output logic             read_isr,
  output logic [LW-1:0]    lowest_lvl
);
  logic [N_IRQ-1:0] imr_d;
  logic             smm_d, ris_d;
  logic [LW-1:0]    low_d;

  always_comb begin
    imr_d = imr;
    smm_d = smm_on;
    ris_d = read_isr;
    low_d = lowest_lvl;
    if (init_hit) begin
      imr_d = '0;
      smm_d = 1'b0;
      ris_d = 1'b0;
      low_d = '1;
    end else begin
      if (mask_wr) imr_d = wr_data[N_IRQ-1:0];
      if (ocw3_wr && wr_data[6]) smm_d = wr_data[5];
      if (ocw3_wr && wr_data[1]) ris_d = wr_data[0];
      if (ocw2_wr && (wr_data[7:5] == 3'b110)) low_d = wr_data[LW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr        <= '0;
      smm_on     <= 1'b0;
      read_isr   <= 1'b0;
      lowest_lvl <= '1;
    end else begin
      imr        <= imr_d;
      smm_on     <= smm_d;
      read_isr   <= ris_d;
      lowest_lvl <= low_d;
    end
  end
endmodule

// File: rtl/pic_edge_bank.sv
module pic_edge_bank #(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_hit,
  input  logic             level_mode,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic [N_IRQ-1:0] ack_clr,
  output logic [N_IRQ-1:0] irr
);
  for (genvar g = 0; g < N_IRQ; g++) begin : g_lane
    logic hist_q, hist_d, req_d, trig;

    always_comb begin
      trig   = ~init_hit & (level_mode | ~hist_q);
      req_d  = irq_in[g] & ((irr[g] & ~ack_clr[g]) | trig);
      hist_d = init_hit | irq_in[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist_q <= 1'b1;
        irr[g] <= 1'b0;
      end else begin
        hist_q <= hist_d;
        irr[g] <= req_d;
      end
    end
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_init_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int DW    = 8,
  localparam int LW   = $clog2(N_IRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic [N_IRQ-1:0] ack_clr,
  output logic             seq_ready,
  output logic             cfg_level,
  output logic             cfg_single,
  output logic             cfg_need4,
  output logic [DW-1:0]    vec_base,
  output logic [DW-1:0]    casc_word,
  output logic [DW-1:0]    mode_word,
  output logic [N_IRQ-1:0] imr,
  output logic             smm_on,
  output logic             read_isr,
  output logic [LW-1:0]    lowest_lvl,
  output logic             edge_rst,
  output logic [N_IRQ-1:0] irr
);
  logic       rst_s1, rst_sync_n;
  logic       init_hit, seq_wr, mask_wr, ocw2_wr, ocw3_wr;
  icw_flags_t flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_sync_n <= rst_s1;
    end
  end

  pic_cmd_decode u_dec (
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .cmd_d4   (wr_data[4]),
    .cmd_d3   (wr_data[3]),
    .ready    (seq_ready),
    .init_hit (init_hit),
    .seq_wr   (seq_wr),
    .mask_wr  (mask_wr),
    .ocw2_wr  (ocw2_wr),
    .ocw3_wr  (ocw3_wr)
  );

  pic_init_fsm #(.DW(DW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .init_hit  (init_hit),
    .seq_wr    (seq_wr),
    .wr_data   (wr_data),
    .seq_ready (seq_ready),
    .flags     (flags),
    .vec_base  (vec_base),
    .casc_word (casc_word),
    .mode_word (mode_word)
  );

  pic_op_regs #(.N_IRQ(N_IRQ), .DW(DW)) u_ops (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .init_hit   (init_hit),
    .mask_wr    (mask_wr),
    .ocw2_wr    (ocw2_wr),
    .ocw3_wr    (ocw3_wr),
    .wr_data    (wr_data),
    .imr        (imr),
    .smm_on     (smm_on),
    .read_isr   (read_isr),
    .lowest_lvl (lowest_lvl)
  );

  pic_edge_bank #(.N_IRQ(N_IRQ)) u_edges (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .init_hit   (init_hit),
    .level_mode (flags.level),
    .irq_in     (irq_in),
    .ack_clr    (ack_clr),
    .irr        (irr)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) edge_rst <= 1'b0;
    else             edge_rst <= init_hit;
  end

  assign cfg_level  = flags.level;
  assign cfg_single = flags.single;
  assign cfg_need4  = flags.need4;
endmodule

// File: rtl/pic_init_seq_chk.sv
module pic_init_seq_chk #(
  parameter int N_IRQ = 8,
  parameter int DW    = 8,
  localparam int LW   = $clog2(N_IRQ)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic [N_IRQ-1:0] irq_in,
  input logic             seq_ready,
  input logic             cfg_level,
  input logic [N_IRQ-1:0] imr,
  input logic             smm_on,
  input logic             read_isr,
  input logic [LW-1:0]    lowest_lvl,
  input logic             edge_rst,
  input logic [N_IRQ-1:0] irr
);
  logic start_w;
  assign start_w = wr_en && !wr_addr && wr_data[4];

  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> (!seq_ready && cfg_level == $past(wr_data[3])));

  p_start_defaults_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> (imr == '0 && !smm_on && !read_isr && lowest_lvl == '1));

  p_pulse_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> edge_rst);

  p_pulse_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !start_w |=> !edge_rst);

  p_need_low_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_level |=> ((irr & ~$past(irr) & $past(irq_in, 2)) == '0));

  p_drop_on_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irr & ~$past(irq_in)) == '0));

  p_level_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_level && !start_w) |=> (irr == $past(irq_in)));

  p_mask_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_ready && wr_en && wr_addr) |=> (imr == $past(wr_data[N_IRQ-1:0]) && seq_ready));

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_ready && wr_en && !start_w) |=> (imr == $past(imr) && smm_on == $past(smm_on)
                                           && read_isr == $past(read_isr)));
endmodule

bind pic_init_seq pic_init_seq_chk #(.N_IRQ(N_IRQ), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .irq_in     (irq_in),
  .seq_ready  (seq_ready),
  .cfg_level  (cfg_level),
  .imr        (imr),
  .smm_on     (smm_on),
  .read_isr   (read_isr),
  .lowest_lvl (lowest_lvl),
  .edge_rst   (edge_rst),
  .irr        (irr)
);

// File: tb/pic_init_seq_test.sv
`timescale 1ns/1ps
module pic_init_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = '0, irq_in = '0, ack_clr = '0;
  logic seq_ready, cfg_level, cfg_single, cfg_need4, smm_on, read_isr, edge_rst;
  logic [7:0] vec_base, casc_word, mode_word, imr, irr;
  logic [2:0] lowest_lvl;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pic_init_seq uut (.*);

  // behavioural reference
  int  rc, m_state;
  bit  m_level, m_single, m_need4, m_smm, m_ris, m_erst;
  logic [7:0] m_irr, m_prev, m_imr, m_vec, m_casc, m_mode;
  logic [2:0] m_low;

  task automatic m_clear();
    m_state = 0; m_level = 0; m_single = 0; m_need4 = 0; m_smm = 0; m_ris = 0; m_erst = 0;
    m_irr = '0; m_prev = '1; m_imr = '0; m_vec = '0; m_casc = '0; m_mode = '0; m_low = 3'd7;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin rc = 0; m_clear(); end
    else if (rc < 2) begin rc++; m_clear(); end
    else begin
      bit hit;
      logic [7:0] nirr;
      hit = wr_en && !wr_addr && wr_data[4];
      for (int i = 0; i < 8; i++)
        nirr[i] = irq_in[i] && ((m_irr[i] && !ack_clr[i]) || (!hit && (m_level || !m_prev[i])));
      m_irr = nirr;
      m_prev = hit ? 8'hFF : irq_in;
      m_erst = hit;
      if (hit) begin
        m_state = 2; m_level = wr_data[3]; m_single = wr_data[1]; m_need4 = wr_data[0];
        m_imr = '0; m_smm = 0; m_ris = 0; m_low = 3'd7;
      end else if (wr_en && m_state != 0) begin
        if (wr_addr) begin
          if (m_state == 2) begin
            m_vec = wr_data;
            m_state = !m_single ? 3 : (m_need4 ? 4 : 0);
          end else if (m_state == 3) begin
            m_casc = wr_data;
            m_state = m_need4 ? 4 : 0;
          end else begin
            m_mode = wr_data;
            m_state = 0;
          end
        end
      end else if (wr_en) begin
        if (wr_addr) m_imr = wr_data;
        else if (wr_data[3]) begin
          if (wr_data[6]) m_smm = wr_data[5];
          if (wr_data[1]) m_ris = wr_data[0];
        end else if (wr_data[7:5] == 3'b110) m_low = wr_data[2:0];
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rc >= 1 && !done) begin
      chk("R2 seq_ready", seq_ready, m_state == 0);
      chk("R1 cfg flags", {cfg_level, cfg_single, cfg_need4}, {m_level, m_single, m_need4});
      chk("R2 init bytes", {vec_base, casc_word, mode_word}, {m_vec, m_casc, m_mode});
      chk("R8 imr", imr, m_imr);
      chk("R9 smm/read", {smm_on, read_isr}, {m_smm, m_ris});
      chk("R10 lowest", lowest_lvl, m_low);
      chk("R4 edge_rst", edge_rst, m_erst);
      chk("R6 irr", irr, m_irr);
    end
  end

  task automatic wr(bit a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic tick(); @(negedge clk); endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) tick();
    rst_n = 1;
    repeat (5) tick();
    chk("R12 reset ready/low", {seq_ready, lowest_lvl, edge_rst}, {1'b1, 3'd7, 1'b0});
    chk("R12 reset regs", {irr, imr, smm_on, read_isr, cfg_level, cfg_single, cfg_need4}, '0);
    // four-byte sequence
    wr(0, 8'h11); chk("R1 busy", seq_ready, 0); chk("R1 need4", cfg_need4, 1);
    wr(1, 8'h40); chk("R2 after byte2", seq_ready, 0);
    wr(1, 8'h04); chk("R2 after byte3", seq_ready, 0); chk("R2 casc", casc_word, 8'h04);
    wr(1, 8'h01); chk("R2 after byte4", seq_ready, 1); chk("R2 mode", mode_word, 8'h01);
    // operation commands
    wr(1, 8'hA5); chk("R8 mask", imr, 8'hA5);
    wr(0, 8'h68); chk("R9 smm set", smm_on, 1);
    wr(0, 8'h0B); chk("R9 read isr", read_isr, 1);
    wr(0, 8'h28); chk("R9 smm no enable", smm_on, 1);
    wr(0, 8'hC3); chk("R10 set lowest", lowest_lvl, 3'd3);
    wr(0, 8'h20); chk("R10 other cmd", lowest_lvl, 3'd3);
    // edge mode latching
    @(negedge clk); irq_in = 8'h01;
    tick(); chk("R6 rise latched", irr, 8'h01);
    tick(); chk("R6 held", irr, 8'h01);
    ack_clr = 8'h01; tick(); ack_clr = 8'h00; chk("R6 ack clears", irr, 8'h00);
    tick(); chk("R6 no relatch while high", irr, 8'h00);
    irq_in = 8'h02; tick(); chk("R6 new rise", irr, 8'h02);
    // restart with inputs high
    irq_in = 8'h06; wr_en = 1; wr_addr = 0; wr_data = 8'h12;
    tick(); wr_en = 0;
    chk("R4 pulse", edge_rst, 1);
    chk("R3 defaults", {imr, smm_on, read_isr, lowest_lvl}, {8'h00, 1'b0, 1'b0, 3'd7});
    chk("R5 rise at restart ignored", irr, 8'h02);
    tick(); chk("R4 pulse ends", edge_rst, 0); chk("R5 still ignored", irr, 8'h02);
    wr(0, 8'h0B); chk("R11 cmd ignored in init", read_isr, 0); chk("R11 busy", seq_ready, 0);
    wr(1, 8'h88); chk("R2 two-byte done", seq_ready, 1); chk("R11 imr kept", imr, 8'h00);
    chk("R2 vec", vec_base, 8'h88);
    irq_in = 8'h02; tick(); irq_in = 8'h06; tick(); chk("R5 fresh rise", irr, 8'h06);
    // level mode
    irq_in = 8'h00; tick();
    wr(0, 8'h1B); chk("R1 level", cfg_level, 1);
    wr(1, 8'h30); chk("R2 skip to byte4", seq_ready, 0);
    wr(1, 8'h02); chk("R2 three-byte done", seq_ready, 1);
    irq_in = 8'h20; tick(); chk("R7 follows", irr, 8'h20);
    ack_clr = 8'h20; tick(); ack_clr = 8'h00; chk("R7 ack no effect", irr, 8'h20);
    irq_in = 8'h00; tick(); chk("R7 drops", irr, 8'h00);
    // restart in mid-sequence
    wr(0, 8'h10); wr(0, 8'h11); chk("R1 restart", seq_ready, 0);
    wr(1, 8'h50); chk("R2 byte2", seq_ready, 0);
    wr(1, 8'h07); chk("R2 byte3", seq_ready, 0);
    wr(1, 8'h03); chk("R2 byte4", seq_ready, 1);
    // mixed stream against the reference
    lf = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      wr_en = (lf[2:0] == 3'd0);
      wr_addr = lf[5];
      wr_data = lf[15:8] ^ lf[7:0];
      if (lf[9:7] == 3'd0) irq_in = irq_in ^ lf[15:8];
      ack_clr = (lf[11:10] == 2'd0) ? lf[7:0] : 8'h00;
    end
    @(negedge clk); wr_en = 0; ack_clr = 0;
    repeat (4) tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule